// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block connects a 16-bit processor core to external memory over a bus on which address and data share the same pins. Two byte-wide pin groups, upper and lower, first carry the access address while an address-latch strobe is high. They then carry data while an active-low read strobe or one of two active-low byte write strobes is asserted. The external board holds the address in a transparent latch that follows the pins while the latch strobe is high and freezes when it falls.

A width-select input picks a 16-bit or an 8-bit external data bus for each access. In 16-bit mode the lower group carries the even byte and the upper group the odd byte, and the write strobes follow the byte enables. In 8-bit mode the upper group shows only address, all data moves over the lower group, and only the low write strobe is used. A word access is split into two byte cycles, even byte first.

The core side is a one-cycle request pulse carrying address, write data, byte enables, direction and an internal-memory flag, answered by a one-cycle acknowledge and a read-data register. A stall input stretches the data phase.

Top module: `muxbus_if`

## Requirements
- R1: After reset, the latch strobe is low, the read and both write strobes are high, neither pin group is driven, the acknowledge is low and the read-data register is zero.
- R2: The cycle after a request is accepted is a one-cycle address phase. In that phase the latch strobe is high, both groups are driven, the upper group shows address bits 15..8, the lower group shows address bits 7..1 plus a bit-0 value, and all strobes are high. The latch strobe is low in the data phase.
- R3: In 16-bit mode, during a write data phase the upper group drives write-data bits 15..8 and the lower group drives bits 7..0. During a read data phase neither group is driven and the read strobe is low. At the end of the read, the enabled bytes are loaded into the read-data register: the lower pins go to bits 7..0 and the upper pins to bits 15..8.
- R4: In 16-bit mode the low write strobe is low during a write data phase when byte enable bit 0 is set. The high write strobe is low when byte enable bit 1 is set. Both are low for a word write.
- R5: In 8-bit mode the upper group is driven with address bits 15..8 through both the address and data phases, for reads and writes alike.
- R6: In 8-bit mode the high write strobe never goes low. The low write strobe is low in the data phase of every write byte cycle.
- R7: In 8-bit mode each enabled byte gets its own address phase and data phase, even byte (enable bit 0) before odd byte (enable bit 1). The lower group's address bit 0 is 0 for the even cycle and 1 for the odd cycle. The lower group carries write-data bits 7..0 or 15..8 respectively, and a read loads the lower pins into the matching half of the read-data register.
- R8: When the quiet-internal control input is high, an access flagged internal keeps the read and both write strobes high for its whole duration. When the control input is low, the strobes behave as for an external access.
- R9: A read flagged internal leaves the read-data register unchanged, whatever is on the pins.
- R10: While the stall input is high in a data phase, that phase repeats with the same strobes and pin values, and no acknowledge is given.
- R11: The acknowledge is high for exactly one cycle, in the cycle after the last data phase of the access. The read-data register holds the new value in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| narrow_i | input | 1 | 1 selects the 8-bit external bus, 0 the 16-bit bus |
| quiet_int_i | input | 1 | 1 suppresses strobes on internal accesses |
| req_i | input | 1 | One-cycle request pulse, taken when idle |
| req_addr_i | input | 16 | Access address |
| req_wdata_i | input | 16 | Write data, odd byte in bits 15..8 |
| req_be_i | input | 2 | Byte enables: bit 0 even byte, bit 1 odd byte |
| req_we_i | input | 1 | 1 write, 0 read |
| req_int_i | input | 1 | Access targets internal memory |
| stall_i | input | 1 | Extends the current data phase |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read-data register |
| hi_out_o | output | 8 | Upper pin group output value |
| hi_oe_o | output | 1 | Upper pin group drive enable |
| hi_in_i | input | 8 | Upper pin group input value |
| lo_out_o | output | 8 | Lower pin group output value |
| lo_oe_o | output | 1 | Lower pin group drive enable |
| lo_in_i | input | 8 | Lower pin group input value |
| ale_o | output | 1 | Address latch strobe, active high |
| rd_n_o | output | 1 | Read strobe, active low |
| wrl_n_o | output | 1 | Even-byte write strobe, active low |
| wrh_n_o | output | 1 | Odd-byte write strobe, active low |

## Verification
The assertions take the width select and the quiet-internal input as steady for the length of an access, since the width is sampled at acceptance but checked against the live pin. They also assume that requests carry at least one byte enable and arrive only while the block is idle. The directed tasks set the width and control inputs before raising the request and leave them alone until the acknowledge. They never issue an empty byte-enable mask, and they raise the next request only after the acknowledge pulse has ended.

// File: rtl/muxbus_if.sv
module muxbus_if (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        narrow_i,
  input  logic        quiet_int_i,
  input  logic        req_i,
  input  logic [15:0] req_addr_i,
  input  logic [15:0] req_wdata_i,
  input  logic [1:0]  req_be_i,
  input  logic        req_we_i,
  input  logic        req_int_i,
  input  logic        stall_i,
  output logic        ack_o,
  output logic [15:0] rdata_o,
  output logic [7:0]  hi_out_o,
  output logic        hi_oe_o,
  input  logic [7:0]  hi_in_i,
  output logic [7:0]  lo_out_o,
  output logic        lo_oe_o,
  input  logic [7:0]  lo_in_i,
  output logic        ale_o,
  output logic        rd_n_o,
  output logic        wrl_n_o,
  output logic        wrh_n_o
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;

  st_t         st;
  logic [15:0] a_q, w_q;
  logic [1:0]  be_q;
  logic        we_q, int_q, nar_q, odd_q;

  wire in_addr = (st == S_ADDR);
  wire in_data = (st == S_DATA);
  wire gate    = !(int_q && quiet_int_i);
  wire wr_ph   = in_data && we_q && gate;

  assign ale_o   = in_addr;
  assign rd_n_o  = !(in_data && !we_q && gate);
  assign wrl_n_o = !(wr_ph && (nar_q || be_q[0]));
  assign wrh_n_o = !(wr_ph && !nar_q && be_q[1]);

  assign hi_oe_o  = in_addr || (in_data && (nar_q || we_q));
  assign hi_out_o = (in_data && we_q && !nar_q) ? w_q[15:8] : a_q[15:8];

  wire [7:0] lo_addr = {a_q[7:1], nar_q ? odd_q : a_q[0]};
  wire [7:0] lo_wd   = (nar_q && odd_q) ? w_q[15:8] : w_q[7:0];

  assign lo_oe_o  = in_addr || (in_data && we_q);
  assign lo_out_o = in_addr ? lo_addr : lo_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      a_q     <= '0;
      w_q     <= '0;
      be_q    <= '0;
      we_q    <= 1'b0;
      int_q   <= 1'b0;
      nar_q   <= 1'b0;
      odd_q   <= 1'b0;
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o <= 1'b0;
      case (st)
        S_IDLE: if (req_i) begin
          a_q   <= req_addr_i;
          w_q   <= req_wdata_i;
          be_q  <= req_be_i;
          we_q  <= req_we_i;
          int_q <= req_int_i;
          nar_q <= narrow_i;
          odd_q <= !req_be_i[0];
          st    <= S_ADDR;
        end
        S_ADDR: st <= S_DATA;
        S_DATA: if (!stall_i) begin
          if (!we_q && !int_q) begin
            if (nar_q) begin
              if (odd_q) rdata_o[15:8] <= lo_in_i;
              else       rdata_o[7:0]  <= lo_in_i;
            end else begin
              if (be_q[0]) rdata_o[7:0]  <= lo_in_i;
              if (be_q[1]) rdata_o[15:8] <= hi_in_i;
            end
          end
          if (nar_q && !odd_q && be_q[1]) begin
            odd_q <= 1'b1;
            st    <= S_ADDR;
          end else begin
            ack_o <= 1'b1;
            st    <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/muxbus_if_chk.sv
module muxbus_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       narrow_i,
  input logic       stall_i,
  input logic       ack_o,
  input logic [7:0] hi_out_o,
  input logic       hi_oe_o,
  input logic       lo_oe_o,
  input logic       ale_o,
  input logic       rd_n_o,
  input logic       wrl_n_o,
  input logic       wrh_n_o
);

  logic [7:0] hi_lat;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     hi_lat <= '0;
    else if (ale_o) hi_lat <= hi_out_o;

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ale_o);

  p_ale_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (rd_n_o && wrl_n_o && wrh_n_o && hi_oe_o && lo_oe_o));

  p_read_undriven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_o && !narrow_i) |-> (!lo_oe_o && !hi_oe_o && wrl_n_o && wrh_n_o));

  p_hi_addr_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_i && (!rd_n_o || !wrl_n_o)) |-> (hi_oe_o && hi_out_o == hi_lat));

  p_wrh_idle_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_i |-> wrh_n_o);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !rd_n_o) |=> (!rd_n_o && !ack_o));

  p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

endmodule

bind muxbus_if muxbus_if_chk i_chk (.*);

// File: tb/test_muxbus_if.sv
module test_muxbus_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        narrow_i = 1'b0, quiet_int_i = 1'b0, req_i = 1'b0;
  logic [15:0] req_addr_i = '0, req_wdata_i = '0;
  logic [1:0]  req_be_i = '0;
  logic        req_we_i = 1'b0, req_int_i = 1'b0, stall_i = 1'b0;
  logic        ack_o;
  logic [15:0] rdata_o;
  logic [7:0]  hi_out_o, lo_out_o;
  logic        hi_oe_o, lo_oe_o;
  logic [7:0]  hi_in_i = '0, lo_in_i = '0;
  logic        ale_o, rd_n_o, wrl_n_o, wrh_n_o;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [15:0] exp_rd = '0;

  always #2.5 clk = ~clk;

  muxbus_if i_muxbus_if (.*);

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input bit nw, input logic [15:0] a, input logic [15:0] wd, input logic [1:0] be,
                     input bit we, input bit intl, input bit qt, input int stl, input logic [15:0] din);
    bit gate, b0;
    string ts;
    gate = !(intl && qt);
    narrow_i = nw; quiet_int_i = qt;
    req_addr_i = a; req_wdata_i = wd; req_be_i = be; req_we_i = we; req_int_i = intl;
    req_i = 1'b1;
    step;
    req_i = 1'b0;
    for (int b = 0; b < 2; b++) begin
      if (nw && !be[b]) continue;
      if (!nw && b == 1) break;
      b0 = nw ? (b == 1) : a[0];
      lo_in_i = nw ? din[8*b +: 8] : din[7:0];
      hi_in_i = din[15:8];
      chk("R2", "ale high", ale_o, 1);
      chk("R2", "upper addr", hi_out_o, a[15:8]);
      chk(nw ? "R7" : "R2", "lower addr", lo_out_o, {a[7:1], b0});
      chk("R2", "addr drive", {hi_oe_o, lo_oe_o}, 2'b11);
      chk("R2", "strobes off", {rd_n_o, wrl_n_o, wrh_n_o}, 3'b111);
      step;
      for (int k = 0; k <= stl; k++) begin
        ts = !gate ? "R8" : (k > 0 ? "R10" : (nw ? "R6" : "R4"));
        chk("R2", "ale low", ale_o, 0);
        chk(!gate ? "R8" : (k > 0 ? "R10" : "R3"), "rd_n", rd_n_o, !(!we && gate));
        chk(ts, "wrl_n", wrl_n_o, !(we && gate && (nw || be[0])));
        chk(ts, "wrh_n", wrh_n_o, !(we && gate && !nw && be[1]));
        if (we) begin
          chk(nw ? "R7" : "R3", "lower drive", lo_oe_o, 1);
          chk(nw ? "R7" : "R3", "lower data", lo_out_o, nw ? wd[8*b +: 8] : wd[7:0]);
          chk(nw ? "R5" : "R3", "upper drive", hi_oe_o, 1);
          chk(nw ? "R5" : "R3", "upper value", hi_out_o, nw ? a[15:8] : wd[15:8]);
        end else begin
          chk("R3", "lower released", lo_oe_o, 0);
          chk(nw ? "R5" : "R3", "upper drive", hi_oe_o, nw);
          if (nw) chk("R5", "upper addr", hi_out_o, a[15:8]);
        end
        chk(k > 0 ? "R10" : "R11", "no ack yet", ack_o, 0);
        stall_i = (k < stl);
        step;
      end
      if (!we && !intl) begin
        if (nw) exp_rd[8*b +: 8] = din[8*b +: 8];
        else begin
          if (be[0]) exp_rd[7:0]  = din[7:0];
          if (be[1]) exp_rd[15:8] = din[15:8];
        end
      end
    end
    chk("R11", "ack", ack_o, 1);
    chk((intl && !we) ? "R9" : (nw ? "R7" : "R11"), "rdata", rdata_o, exp_rd);
    step;
    chk("R11", "ack single", ack_o, 0);
  endtask

  task automatic t_reset;
    chk("R1", "ale", ale_o, 0);
    chk("R1", "strobes", {rd_n_o, wrl_n_o, wrh_n_o}, 3'b111);
    chk("R1", "drive", {hi_oe_o, lo_oe_o}, 2'b00);
    chk("R1", "ack", ack_o, 0);
    chk("R1", "rdata", rdata_o, 16'h0000);
  endtask

  task automatic t_wide_write;
    run(0, 16'h12A4, 16'hBEEF, 2'b11, 1, 0, 0, 0, 16'h0);
    run(0, 16'h3456, 16'h00C3, 2'b01, 1, 0, 0, 0, 16'h0);
    run(0, 16'h7F01, 16'h5A00, 2'b10, 1, 0, 0, 0, 16'h0);
  endtask

  task automatic t_wide_read;
    run(0, 16'h8000, 16'h0, 2'b11, 0, 0, 0, 0, 16'hCAFE);
    run(0, 16'h8002, 16'h0, 2'b01, 0, 0, 0, 0, 16'h1177);
    run(0, 16'h8005, 16'h0, 2'b10, 0, 0, 0, 0, 16'h9944);
  endtask

  task automatic t_narrow;
    run(1, 16'hA5C2, 16'h6789, 2'b11, 1, 0, 0, 0, 16'h0);
    run(1, 16'h4433, 16'hF00D, 2'b10, 1, 0, 0, 0, 16'h0);
    run(1, 16'h0F10, 16'h0, 2'b11, 0, 0, 0, 0, 16'h2B3C);
    run(1, 16'h0F20, 16'h0, 2'b01, 0, 0, 0, 0, 16'hEE81);
  endtask

  task automatic t_internal;
    run(0, 16'h0100, 16'h1234, 2'b11, 1, 1, 1, 0, 16'h0);
    run(0, 16'h0102, 16'h0, 2'b11, 0, 1, 1, 0, 16'hD00D);
    run(0, 16'h0104, 16'h4321, 2'b11, 1, 1, 0, 0, 16'h0);
    run(0, 16'h0106, 16'h0, 2'b11, 0, 1, 0, 0, 16'h7E7E);
    run(1, 16'h0108, 16'h0, 2'b11, 0, 1, 1, 0, 16'h5151);
  endtask

  task automatic t_stall;
    run(0, 16'h2222, 16'hABCD, 2'b11, 1, 0, 0, 3, 16'h0);
    run(1, 16'h3330, 16'h0, 2'b11, 0, 0, 0, 2, 16'h6D4E);
  endtask

  initial begin
    step; step;
    t_reset;
    rst_n = 1'b1;
    step;
    t_reset;
    t_wide_write;
    t_wide_read;
    t_narrow;
    t_internal;
    t_stall;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule